// File: doc/BRIEF.md
# PWM Step-Time Search Engine

This block picks the timing configuration of a pulse-width modulator frame. It takes a requested frame period in nanoseconds and searches a fixed set of step-time settings for the one closest to that period. Each setting is made of three parts: a reference clock (one of three), a pre-divider (one of four), and a power-of-two exponent from 0 to 7. The block also picks the counter size, 6-bit or 9-bit. Conversion from microseconds and the duty-cycle value are worked out by the logic around it.

The engine first divides the period by 64 to get the step time for a 6-bit counter. If that step cannot be reached with the largest setting, it switches to a 9-bit counter and divides by 8 more. It then walks the clocks, within each clock the dividers, and within each divider the exponents, taking one candidate per clock cycle. The candidate doubles with every exponent step. An exponent walk is cut short as soon as the error starts to grow. When the walk is complete, a one-cycle `done` pulse presents the chosen setting. The setting then stays on the outputs until the next search completes.

Top module: `pwm_step_search`

## Requirements
- R1: After reset, `done` is low and `res_wide`, `res_clk`, `res_div` and `res_exp` are all zero.
- R2: The working step is `target_ns >> 6`. If this value is at least 749999616 (the largest table entry shifted left by 7), `res_wide` is 1 (9-bit counter) and the working step is shifted right by a further 3. Otherwise `res_wide` is 0 (6-bit counter).
- R3: The candidate for clock index c, divider index d and exponent m is `step(c,d) << m`, where `step(c,d)` is the base period times the factor. The base periods are 976562, 30517 and 52 ns for c = 0, 1 and 2. The factors are 1, 3, 5 and 6 for d = 0, 1, 2 and 3. The exponent m runs from 0 to 7.
- R4: The reported `res_clk`, `res_div` and `res_exp` select a candidate with the smallest absolute difference from the working step, among all candidates visited.
- R5: Candidates are visited in this order: clock index outer, divider index middle, exponent inner. The best result is replaced only on a strictly smaller error, so on a tie the first candidate found is reported.
- R6: For m above 0, the exponent walk of a divider stops after evaluating a candidate whose error is greater than the error of the previous candidate. An equal error does not stop the walk.
- R7: One candidate is evaluated per clock cycle. If the start is sampled at edge E, `done` is high for exactly one cycle after edge E+N, where N is the number of candidates visited.
- R8: A `start` pulse received while a search is in progress is ignored. The running search keeps its target, its result and its timing.
- R9: `res_wide`, `res_clk`, `res_div` and `res_exp` change only at the edge that raises `done`, and are held until the next search completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a search when idle; sampled with `target_ns` |
| target_ns | input | TGT_W (40) | Requested frame period in ns |
| done | output | 1 | One-cycle pulse when the result is valid |
| res_wide | output | 1 | 1 = 9-bit counter, 0 = 6-bit counter |
| res_clk | output | 2 | Chosen reference clock index |
| res_div | output | 2 | Chosen pre-divider index |
| res_exp | output | 3 | Chosen exponent |

## Verification
The assertions take for granted that `start` is a single-cycle pulse sampled together with a stable `target_ns`. They also assume `target_ns` stays below 2^40, so that both the working step and every error fit in 32 bits. The bench raises `start` and changes `target_ns` only on falling edges, and it holds `start` for one cycle. Its targets range from zero to about 3.8e11 ns, which stays inside that bound. A second start is placed in the middle of a search only on purpose, to check that it is ignored.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int NCLK          = 3;
  localparam int NDIV          = 4;
  localparam int MMAX          = 7;
  localparam int WW            = 32;
  localparam int SMALL_SH      = 6;
  localparam int WIDE_EXTRA_SH = 3;
  localparam int CLK_W         = $clog2(NCLK);
  localparam int DIV_W         = $clog2(NDIV);
  localparam int EXP_W         = $clog2(MMAX + 1);

  typedef logic [WW-1:0] word_t;

  typedef struct packed {
    logic             wide;
    logic [CLK_W-1:0] clk_i;
    logic [DIV_W-1:0] div_i;
    logic [EXP_W-1:0] expo;
  } pick_t;

  // reference clock period in whole nanoseconds, truncated
  function automatic word_t ref_period_ns(input int c);
    case (c)
      0:       return word_t'(976562);
      1:       return word_t'(30517);
      default: return word_t'(52);
    endcase
  endfunction

  function automatic word_t div_factor(input int d);
    case (d)
      0:       return word_t'(1);
      1:       return word_t'(3);
      2:       return word_t'(5);
      default: return word_t'(6);
    endcase
  endfunction

  function automatic word_t step_ns(input int c, input int d);
    return ref_period_ns(c) * div_factor(d);
  endfunction

  // largest reachable step: biggest table entry at the top exponent
  function automatic logic [63:0] reach_limit();
    logic [63:0] mx;
    mx = '0;
    for (int c = 0; c < NCLK; c++)
      for (int d = 0; d < NDIV; d++)
        if (64'(step_ns(c, d)) > mx) mx = 64'(step_ns(c, d));
    return mx << MMAX;
  endfunction

  function automatic word_t abs_gap(input word_t a, input word_t b);
    return (a > b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/pss_prep.sv
module pss_prep
  import pss_pkg::*;
#(
  parameter int TGT_W = 40
) (
  input  logic [TGT_W-1:0] target_ns,
  output logic             wide,
  output word_t            work
);
  localparam int          RAW_W = TGT_W - SMALL_SH;
  localparam logic [63:0] LIM   = reach_limit();

  logic [RAW_W-1:0] raw;
  logic [RAW_W-1:0] narrowed;

  always_comb begin
    raw      = target_ns[TGT_W-1:SMALL_SH];
    wide     = (64'(raw) >= LIM);
    narrowed = wide ? (raw >> WIDE_EXTRA_SH) : raw;
    work     = word_t'(narrowed);
  end
endmodule

// File: rtl/pss_rom.sv
module pss_rom
  import pss_pkg::*;
(
  input  logic [CLK_W-1:0] clk_i,
  input  logic [DIV_W-1:0] div_i,
  output word_t            step
);
  localparam int NENT = NCLK * NDIV;

  word_t entry [NENT];

  for (genvar c = 0; c < NCLK; c++) begin : g_clk
    for (genvar d = 0; d < NDIV; d++) begin : g_div
      assign entry[c*NDIV+d] = step_ns(c, d);
    end
  end

  always_comb begin
    step = entry[0];
    for (int k = 0; k < NENT; k++)
      if (k == int'(clk_i) * NDIV + int'(div_i)) step = entry[k];
  end
endmodule

// File: rtl/pss_score.sv
module pss_score
  import pss_pkg::*;
(
  input  word_t work,
  input  word_t cand,
  input  word_t best_err,
  input  word_t prev_err,
  input  logic  not_first,
  output word_t err,
  output logic  better,
  output logic  rising
);
  always_comb begin
    err    = abs_gap(work, cand);
    better = err < best_err;
    rising = not_first && (err > prev_err);
  end
endmodule

// File: rtl/pwm_step_search.sv
module pwm_step_search
  import pss_pkg::*;
#(
  parameter int TGT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TGT_W-1:0] target_ns,
  output logic             done,
  output logic             res_wide,
  output logic [CLK_W-1:0] res_clk,
  output logic [DIV_W-1:0] res_div,
  output logic [EXP_W-1:0] res_exp
);
  localparam logic [CLK_W-1:0] LAST_CLK = CLK_W'(NCLK - 1);
  localparam logic [DIV_W-1:0] LAST_DIV = DIV_W'(NDIV - 1);
  localparam logic [EXP_W-1:0] LAST_EXP = EXP_W'(MMAX);

  logic             busy_q, done_q, wide_q;
  logic [CLK_W-1:0] ci_q, nxt_ci;
  logic [DIV_W-1:0] di_q, nxt_di;
  logic [EXP_W-1:0] m_q;
  word_t            cand_q, work_q, min_err_q, prev_err_q;
  pick_t            best_q, best_nxt, res_q;

  // named internal events
  logic  accept, better, rising, inner_end, search_end;
  logic  wide_in;
  word_t work_in, cur_err, step_nxt;

  pss_prep #(.TGT_W(TGT_W)) u_prep (
    .target_ns (target_ns),
    .wide      (wide_in),
    .work      (work_in)
  );

  pss_rom u_rom (
    .clk_i (nxt_ci),
    .div_i (nxt_di),
    .step  (step_nxt)
  );

  pss_score u_score (
    .work      (work_q),
    .cand      (cand_q),
    .best_err  (min_err_q),
    .prev_err  (prev_err_q),
    .not_first (m_q != '0),
    .err       (cur_err),
    .better    (better),
    .rising    (rising)
  );

  assign accept     = start && !busy_q;
  assign inner_end  = rising || (m_q == LAST_EXP);
  assign search_end = busy_q && inner_end && (di_q == LAST_DIV) && (ci_q == LAST_CLK);

  always_comb begin
    nxt_ci = ci_q;
    nxt_di = di_q;
    if (accept) begin
      nxt_ci = '0;
      nxt_di = '0;
    end else if (inner_end) begin
      if (di_q == LAST_DIV) begin
        nxt_di = '0;
        nxt_ci = ci_q + 1'b1;
      end else begin
        nxt_di = di_q + 1'b1;
      end
    end
  end

  always_comb begin
    best_nxt      = best_q;
    best_nxt.wide = wide_q;
    if (busy_q && better) begin
      best_nxt.clk_i = ci_q;
      best_nxt.div_i = di_q;
      best_nxt.expo  = m_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      wide_q     <= 1'b0;
      ci_q       <= '0;
      di_q       <= '0;
      m_q        <= '0;
      cand_q     <= '0;
      work_q     <= '0;
      min_err_q  <= '1;
      prev_err_q <= '1;
      best_q     <= '0;
      res_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q     <= 1'b1;
        work_q     <= work_in;
        wide_q     <= wide_in;
        ci_q       <= '0;
        di_q       <= '0;
        m_q        <= '0;
        cand_q     <= step_nxt;
        min_err_q  <= '1;
        prev_err_q <= '1;
        best_q     <= '0;
      end else if (busy_q) begin
        best_q <= best_nxt;
        if (better) min_err_q <= cur_err;
        // on an early exit the earlier error is kept, as the walk leaves
        if (!rising) prev_err_q <= cur_err;
        if (inner_end) begin
          m_q    <= '0;
          ci_q   <= nxt_ci;
          di_q   <= nxt_di;
          cand_q <= step_nxt;
        end else begin
          m_q    <= m_q + 1'b1;
          cand_q <= cand_q << 1;
        end
        if (search_end) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= best_nxt;
        end
      end
    end
  end

  assign done     = done_q;
  assign res_wide = res_q.wide;
  assign res_clk  = res_q.clk_i;
  assign res_div  = res_q.div_i;
  assign res_exp  = res_q.expo;
endmodule

// File: rtl/pss_chk.sv
module pss_chk
  import pss_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             brk,
  input logic [EXP_W-1:0] m_idx,
  input word_t            min_err,
  input word_t            work,
  input pick_t            res
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R6
  early_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && brk) |=> (m_idx == '0));

  // R3
  exp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !brk && (m_idx != EXP_W'(MMAX))) |=> (m_idx == $past(m_idx) + 1'b1));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(work));

  // R4
  min_err_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (min_err <= $past(min_err)));

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(res));
endmodule

bind pwm_step_search pss_chk u_pss_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy_q),
  .done    (done_q),
  .brk     (rising),
  .m_idx   (m_q),
  .min_err (min_err_q),
  .work    (work_q),
  .res     (res_q)
);

// File: tb/pwm_step_search_bench.sv
module pwm_step_search_bench;
  import pss_pkg::*;

  localparam int TGT_W = 40;
  localparam int NV    = 7;

  // target, expected {wide, clk, div, exp}, expected candidate count
  localparam logic [TGT_W-1:0] V_TGT [NV] = '{
    40'd3328, 40'd0, 40'd7812352, 40'd4992,
    40'd47999975360, 40'd47999975424, 40'd383999803392};
  localparam int V_WIDE [NV] = '{0, 0, 0, 0, 0, 1, 1};
  localparam int V_CLK  [NV] = '{2, 2, 1, 2, 0, 0, 0};
  localparam int V_DIV  [NV] = '{0, 0, 0, 0, 3, 1, 3};
  localparam int V_EXP  [NV] = '{0, 0, 2, 0, 7, 5, 7};
  localparam int V_CYC  [NV] = '{24, 24, 50, 25, 96, 91, 96};
  localparam string V_TAG [NV] = '{"R4", "R4", "R3", "R5", "R2", "R2", "R2"};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [TGT_W-1:0] target_ns = '0;
  logic             done, res_wide;
  logic [CLK_W-1:0] res_clk;
  logic [DIV_W-1:0] res_div;
  logic [EXP_W-1:0] res_exp;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwm_step_search #(.TGT_W(TGT_W)) u_pwm_step_search (
    .clk (clk), .rst_n (rst_n), .start (start), .target_ns (target_ns),
    .done (done), .res_wide (res_wide), .res_clk (res_clk),
    .res_div (res_div), .res_exp (res_exp)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_done(inout int cyc);
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_res(input string tag, input int i);
    chk(tag, "wide", longint'(res_wide), longint'(V_WIDE[i]));
    chk(tag, "clk",  longint'(res_clk),  longint'(V_CLK[i]));
    chk(tag, "div",  longint'(res_div),  longint'(V_DIV[i]));
    chk(tag, "exp",  longint'(res_exp),  longint'(V_EXP[i]));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog: actual no completion expected completion");
    summary();
    $finish;
  end

  initial begin
    int cyc;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", longint'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "done", longint'(done), 0);
    chk("R1", "result", longint'({res_wide, res_clk, res_div, res_exp}), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      target_ns = V_TGT[i];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      wait_done(cyc);
      chk(V_TAG[i], "done seen", longint'(done), 1);
      check_res(V_TAG[i], i);
      // R6 early exit and R7 one candidate per cycle, seen as latency
      chk("R6", "cycles to done", longint'(cyc), longint'(V_CYC[i]));
      @(negedge clk);
      chk("R7", "done width", longint'(done), 0);
      repeat (3) @(negedge clk);
      // R9 result held after done
      check_res("R9", i);
    end

    // R8: a second start during a search is ignored
    @(negedge clk);
    target_ns = V_TGT[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    repeat (5) begin
      @(negedge clk);
      cyc++;
    end
    target_ns = V_TGT[2];
    start = 1'b1;
    @(negedge clk);
    cyc++;
    start = 1'b0;
    wait_done(cyc);
    check_res("R8", 0);
    chk("R8", "cycles with extra start", longint'(cyc), longint'(V_CYC[0]));

    // R9: results unchanged while a new search runs, then updated at done
    @(negedge clk);
    target_ns = V_TGT[5];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check_res("R9", 0);
    cyc = 11;
    wait_done(cyc);
    check_res("R9", 5);

    summary();
    $finish;
  end
endmodule